// File: doc/BRIEF.md
# Two-Channel Timer Output Reference Generator

This block turns a free-running timer count into waveform reference levels for two compare channels. A shared counter counts up, counts down, or counts up and down (center-aligned) between zero and an auto-reload limit. Each channel compares the count against its own compare value and, according to a 4-bit mode, drives a reference level. The modes are fixed levels, match-driven set, clear and toggle, two PWM polarities, and two retriggerable one-pulse variants. A third output, the merged reference of channel 1, can carry the OR or the AND of both channel references, or it can pick between them by counting direction. This gives combined and asymmetric PWM.

The limit and the compare values are written into preload registers. They move into the active registers only on an update event. An update event happens at the wrap or turnaround point of the counter, or when `upd_req` is pulsed. The pulse also restarts the counter. A trigger input arms the one-pulse modes and restarts the count, so a later trigger stretches the pulse.

Top module: `tim_ocref_unit`

## Requirements
- R1: After reset, `cnt` is 0 and all references are low. In up mode (`cnt_mode`=0) with `run` high, `cnt` steps by one from 0 to the active limit inclusive and then returns to 0. `update_evt` is high in the cycle where `cnt` equals the limit.
- R2: In down mode (`cnt_mode`=1), `cnt` steps from the limit down to 0 and then reloads the limit. `cnt_down` is high and `update_evt` is high at 0. In center mode (`cnt_mode`=2 or 3), `cnt` rises to the limit and then falls to 0, with `update_evt` high at both turning points. `cnt_down` is low while rising and high while falling.
- R3: Writes to the limit and the compare values take effect only at the next update event. A write in the same cycle as an update is taken at once. `upd_req` loads the preload values and restarts the counter at 0, or at the new limit in down mode.
- R4: With compare value C, mode 6 (PWM A) is high when `cnt`<C while counting up and when `cnt`<=C while counting down. Mode 7 (PWM B) is the complement of mode 6. So C=0 gives a constant low in mode 6 when counting up, and C above the limit gives a constant high.
- R5: Mode 1 sets the reference high, and mode 2 sets it low, in the cycle after one where `cnt` equals the compare value. The level then holds.
- R6: Mode 3 inverts the reference in the cycle after each cycle where `cnt` equals the compare value.
- R7: Mode 4 forces the reference low and mode 5 forces it high, both at once. Mode 0 (and the unused codes 10 and 11) holds the last level.
- R8: Mode 8 (one-pulse A) rests high when counting up and low when counting down. From the cycle after `trig`, it follows PWM A until the next update event, and then it rests again.
- R9: Mode 9 (one-pulse B) is the complement of mode 8. It rests low when counting up and high when counting down, and follows PWM B while armed.
- R10: When either channel is in mode 8 or 9, `trig` restarts the counter on the next edge without an update event. The counter restarts at 0, or at the active limit in down mode. This also happens while a pulse is in progress.
- R11: With channel 1 in mode 12, `ref1_merged` is `ref1` OR `ref2`, where `ref1` acts as PWM A. With channel 1 in mode 13, it is the AND, where `ref1` acts as PWM B. In modes 0 to 11, `ref1_merged` equals `ref1`.
- R12: With channel 1 in mode 14 (`ref1` acts as PWM A) or mode 15 (`ref1` acts as PWM B), `ref1_merged` is `ref1` while `cnt_down` is low and `ref2` while it is high.
- R13: With `run` low and no `upd_req` or restart, `cnt` holds and no match event changes any reference level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter enable |
| cnt_mode | input | 2 | 0 up, 1 down, 2/3 center-aligned |
| upd_req | input | 1 | Forced update: load preloads, restart count |
| trig | input | 1 | Trigger for one-pulse modes |
| arr_we | input | 1 | Write strobe for limit preload |
| arr_wdata | input | CNT_W | Limit value |
| cmp1_we | input | 1 | Write strobe for channel 1 compare preload |
| cmp1_wdata | input | CNT_W | Channel 1 compare value |
| cmp2_we | input | 1 | Write strobe for channel 2 compare preload |
| cmp2_wdata | input | CNT_W | Channel 2 compare value |
| mode1 | input | 4 | Channel 1 mode |
| mode2 | input | 4 | Channel 2 mode |
| cnt | output | CNT_W | Current count |
| cnt_down | output | 1 | Counting direction, high when down |
| update_evt | output | 1 | Update event in this cycle |
| ref1 | output | 1 | Channel 1 reference |
| ref2 | output | 1 | Channel 2 reference |
| ref1_merged | output | 1 | Merged channel 1 reference |

## Verification
The compare references are combinational from the registered count and the active compare value, so they are checked in the same sample as the count they depend on. `update_evt` is also checked in the same sample, because it depends on `upd_req`. Count steps, preload transfers, one-pulse arming and trigger restarts become visible one edge later. Match, toggle and freeze levels show up in the sample after the one where the count equals the compare value. Each task drives its inputs shortly after a rising edge, waits one nanosecond, and then compares the outputs. Because of this, every check falls between edges, and it is counted against the edge that produced the expected change.

// File: rtl/tim_ocref_pkg.sv
package tim_ocref_pkg;

    typedef enum logic [3:0] {
        OC_FROZEN   = 4'd0,
        OC_SET_HIT  = 4'd1,
        OC_CLR_HIT  = 4'd2,
        OC_TOGGLE   = 4'd3,
        OC_FORCE_LO = 4'd4,
        OC_FORCE_HI = 4'd5,
        OC_PWM_A    = 4'd6,
        OC_PWM_B    = 4'd7,
        OC_OPM_A    = 4'd8,
        OC_OPM_B    = 4'd9,
        OC_RSV_A    = 4'd10,
        OC_RSV_B    = 4'd11,
        OC_COMB_OR  = 4'd12,
        OC_COMB_AND = 4'd13,
        OC_ASYM_A   = 4'd14,
        OC_ASYM_B   = 4'd15
    } oc_mode_e;

    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_CENTER = 2'd2,
        CNT_CTR2   = 2'd3
    } cnt_mode_e;

    function automatic logic is_one_pulse(input logic [3:0] m);
        return (m == OC_OPM_A) || (m == OC_OPM_B);
    endfunction

endpackage

// File: rtl/tim_ocref_counter.sv
module tim_ocref_counter
    import tim_ocref_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       cnt_mode,
    input  logic             upd_req,
    input  logic             restart,
    input  logic             arr_we,
    input  logic [CNT_W-1:0] arr_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic [CNT_W-1:0] arr_act,
    output logic             upd
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic [CNT_W-1:0] arr_pre;
        logic [CNT_W-1:0] arr_act;
    } ctr_state_t;

    ctr_state_t s_d, s_q;
    logic center, down_mode, at_end;

    always_comb begin
        center    = cnt_mode[1];
        down_mode = (cnt_mode == CNT_DOWN);
        if (center) begin
            at_end = s_q.down ? (s_q.cnt == '0) : (s_q.cnt >= s_q.arr_act);
        end else if (down_mode) begin
            at_end = (s_q.cnt == '0);
        end else begin
            at_end = (s_q.cnt >= s_q.arr_act);
        end
        upd = upd_req | (run & at_end & ~restart);

        s_d = s_q;
        if (arr_we) s_d.arr_pre = arr_wdata;
        if (upd)    s_d.arr_act = s_d.arr_pre;
        if (!center) s_d.down = down_mode;

        if (upd_req) begin
            s_d.cnt = down_mode ? s_d.arr_pre : '0;
            if (center) s_d.down = 1'b0;
        end else if (restart) begin
            s_d.cnt = down_mode ? s_q.arr_act : '0;
            if (center) s_d.down = 1'b0;
        end else if (run) begin
            if (center) begin
                if (!s_q.down) begin
                    if (at_end) begin
                        s_d.down = 1'b1;
                        s_d.cnt  = (s_q.cnt != '0) ? s_q.cnt - ONE : '0;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end else begin
                    if (at_end) begin
                        s_d.down = 1'b0;
                        s_d.cnt  = (s_d.arr_act != '0) ? ONE : '0;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE;
                    end
                end
            end else if (down_mode) begin
                s_d.cnt = at_end ? s_d.arr_act : s_q.cnt - ONE;
            end else begin
                s_d.cnt = at_end ? '0 : s_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt     = s_q.cnt;
    assign down    = s_q.down;
    assign arr_act = s_q.arr_act;

endmodule

// File: rtl/tim_ocref_chan.sv
module tim_ocref_chan
    import tim_ocref_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             down,
    input  logic             upd,
    input  logic             trig,
    input  logic [3:0]       mode,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             ref_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp_pre;
        logic [CNT_W-1:0] cmp_act;
        logic             level;
        logic             armed;
    } chan_state_t;

    chan_state_t s_d, s_q;
    oc_mode_e    m;
    logic        pwm_a, pwm_b, hit;

    always_comb begin
        m     = oc_mode_e'(mode);
        pwm_a = down ? (cnt <= s_q.cmp_act) : (cnt < s_q.cmp_act);
        pwm_b = ~pwm_a;
        hit   = run && (cnt == s_q.cmp_act);

        s_d = s_q;
        if (cmp_we) s_d.cmp_pre = cmp_wdata;
        if (upd)    s_d.cmp_act = s_d.cmp_pre;

        if (!is_one_pulse(mode)) s_d.armed = 1'b0;
        else if (trig)           s_d.armed = 1'b1;
        else if (upd)            s_d.armed = 1'b0;

        ref_o = s_q.level;
        case (m)
            OC_SET_HIT: if (hit) s_d.level = 1'b1;
            OC_CLR_HIT: if (hit) s_d.level = 1'b0;
            OC_TOGGLE:  if (hit) s_d.level = ~s_q.level;
            OC_FORCE_LO: begin
                ref_o       = 1'b0;
                s_d.level   = 1'b0;
            end
            OC_FORCE_HI: begin
                ref_o       = 1'b1;
                s_d.level   = 1'b1;
            end
            OC_PWM_A, OC_COMB_OR, OC_ASYM_A: begin
                ref_o     = pwm_a;
                s_d.level = pwm_a;
            end
            OC_PWM_B, OC_COMB_AND, OC_ASYM_B: begin
                ref_o     = pwm_b;
                s_d.level = pwm_b;
            end
            OC_OPM_A: begin
                ref_o     = s_q.armed ? pwm_a : ~down;
                s_d.level = ref_o;
            end
            OC_OPM_B: begin
                ref_o     = s_q.armed ? pwm_b : down;
                s_d.level = ref_o;
            end
            default: ref_o = s_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tim_ocref_merge.sv
module tim_ocref_merge
    import tim_ocref_pkg::*;
(
    input  logic [3:0] mode1,
    input  logic       ref1,
    input  logic       ref2,
    input  logic       down,
    output logic       merged
);
    always_comb begin
        case (oc_mode_e'(mode1))
            OC_COMB_OR:           merged = ref1 | ref2;
            OC_COMB_AND:          merged = ref1 & ref2;
            OC_ASYM_A, OC_ASYM_B: merged = down ? ref2 : ref1;
            default:              merged = ref1;
        endcase
    end
endmodule

// File: rtl/tim_ocref_unit.sv
module tim_ocref_unit
    import tim_ocref_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       cnt_mode,
    input  logic             upd_req,
    input  logic             trig,
    input  logic             arr_we,
    input  logic [CNT_W-1:0] arr_wdata,
    input  logic             cmp1_we,
    input  logic [CNT_W-1:0] cmp1_wdata,
    input  logic             cmp2_we,
    input  logic [CNT_W-1:0] cmp2_wdata,
    input  logic [3:0]       mode1,
    input  logic [3:0]       mode2,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_down,
    output logic             update_evt,
    output logic             ref1,
    output logic             ref2,
    output logic             ref1_merged
);
    localparam int NUM_CH = 2;

    logic [CNT_W-1:0] arr_act;
    logic             restart;
    logic             ch_we   [NUM_CH];
    logic [CNT_W-1:0] ch_wdat [NUM_CH];
    logic [3:0]       ch_mode [NUM_CH];
    logic             ch_ref  [NUM_CH];

    assign restart = trig & (is_one_pulse(mode1) | is_one_pulse(mode2));

    assign ch_we[0]   = cmp1_we;
    assign ch_we[1]   = cmp2_we;
    assign ch_wdat[0] = cmp1_wdata;
    assign ch_wdat[1] = cmp2_wdata;
    assign ch_mode[0] = mode1;
    assign ch_mode[1] = mode2;

    tim_ocref_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cnt_mode  (cnt_mode),
        .upd_req   (upd_req),
        .restart   (restart),
        .arr_we    (arr_we),
        .arr_wdata (arr_wdata),
        .cnt       (cnt),
        .down      (cnt_down),
        .arr_act   (arr_act),
        .upd       (update_evt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tim_ocref_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .cnt       (cnt),
            .down      (cnt_down),
            .upd       (update_evt),
            .trig      (trig),
            .mode      (ch_mode[g]),
            .cmp_we    (ch_we[g]),
            .cmp_wdata (ch_wdat[g]),
            .ref_o     (ch_ref[g])
        );
    end

    assign ref1 = ch_ref[0];
    assign ref2 = ch_ref[1];

    tim_ocref_merge u_merge (
        .mode1  (mode1),
        .ref1   (ch_ref[0]),
        .ref2   (ch_ref[1]),
        .down   (cnt_down),
        .merged (ref1_merged)
    );

endmodule

// File: rtl/tim_ocref_unit_chk.sv
module tim_ocref_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [1:0]       cnt_mode,
    input logic             upd_req,
    input logic             restart,
    input logic [3:0]       mode1,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_down,
    input logic [CNT_W-1:0] arr_act,
    input logic             ref1,
    input logic             ref2,
    input logic             ref1_merged
);
    assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd0 && run && !upd_req && !restart && cnt < arr_act)
        |=> cnt == $past(cnt) + CNT_W'(1));

    assert_up_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd0 && run && !upd_req && !restart && cnt >= arr_act)
        |=> cnt == '0);

    assert_down_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd1) |=> cnt_down);

    assert_force_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == 4'd5) |-> ref1);

    assert_force_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == 4'd4) |-> !ref1);

    assert_retrig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && cnt_mode != 2'd1) |=> cnt == '0);

    assert_comb_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == 4'd12 && !ref1_merged) |-> (!ref1 && !ref2));

    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !upd_req && !restart) |=> $stable(cnt));
endmodule

bind tim_ocref_unit tim_ocref_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cnt_mode    (cnt_mode),
    .upd_req     (upd_req),
    .restart     (restart),
    .mode1       (mode1),
    .cnt         (cnt),
    .cnt_down    (cnt_down),
    .arr_act     (arr_act),
    .ref1        (ref1),
    .ref2        (ref2),
    .ref1_merged (ref1_merged)
);

// File: tb/tim_ocref_unit_tb.sv
`timescale 1ns/1ps
module tim_ocref_unit_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [1:0] cnt_mode = 2'd0;
    logic upd_req = 1'b0, trig = 1'b0;
    logic arr_we = 1'b0, cmp1_we = 1'b0, cmp2_we = 1'b0;
    logic [W-1:0] arr_wdata = '0, cmp1_wdata = '0, cmp2_wdata = '0;
    logic [3:0] mode1 = 4'd0, mode2 = 4'd0;
    logic [W-1:0] cnt;
    logic cnt_down, update_evt, ref1, ref2, ref1_merged;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tim_ocref_unit #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt_mode(cnt_mode),
        .upd_req(upd_req), .trig(trig),
        .arr_we(arr_we), .arr_wdata(arr_wdata),
        .cmp1_we(cmp1_we), .cmp1_wdata(cmp1_wdata),
        .cmp2_we(cmp2_we), .cmp2_wdata(cmp2_wdata),
        .mode1(mode1), .mode2(mode2),
        .cnt(cnt), .cnt_down(cnt_down), .update_evt(update_evt),
        .ref1(ref1), .ref2(ref2), .ref1_merged(ref1_merged)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic int pwm_a(input int c, input int cmp, input int dn);
        return dn != 0 ? int'(c <= cmp) : int'(c < cmp);
    endfunction

    task automatic load(input int a, input int c1, input int c2);
        run = 1'b0;
        arr_we = 1'b1; arr_wdata = W'(a);
        cmp1_we = 1'b1; cmp1_wdata = W'(c1);
        cmp2_we = 1'b1; cmp2_wdata = W'(c2);
        upd_req = 1'b1;
        cyc();
        arr_we = 1'b0; cmp1_we = 1'b0; cmp2_we = 1'b0; upd_req = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 reset cnt", int'(cnt), 0);
        chk("R1 reset ref1", int'(ref1), 0);
        chk("R1 reset ref2", int'(ref2), 0);
        chk("R1 reset merged", int'(ref1_merged), 0);
        chk("R1 reset update", int'(update_evt), 0);
    endtask

    task automatic t_count_up();
        int seqc[6] = '{3, 4, 0, 1, 2, 0};
        int sequ[6] = '{0, 1, 0, 0, 1, 0};
        cnt_mode = 2'd0; mode1 = 4'd0; mode2 = 4'd0;
        load(4, 0, 0);
        run = 1'b1;
        for (int i = 0; i < 7; i++) begin
            #1;
            chk("R1 up cnt", int'(cnt), i % 5);
            chk("R1 up update", int'(update_evt), int'(i % 5 == 4));
            cyc();
        end
        arr_we = 1'b1; arr_wdata = W'(2);
        #1;
        chk("R1 up cnt before write", int'(cnt), 2);
        cyc();
        arr_we = 1'b0;
        for (int k = 0; k < 6; k++) begin
            #1;
            chk("R3 limit preload cnt", int'(cnt), seqc[k]);
            chk("R3 limit preload update", int'(update_evt), sequ[k]);
            cyc();
        end
        run = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R13 hold cnt", int'(cnt), 1);
            cyc();
        end
    endtask

    task automatic t_pwm_up();
        cnt_mode = 2'd0; mode1 = 4'd6; mode2 = 4'd7;
        load(5, 2, 2);
        run = 1'b1;
        for (int i = 0; i < 12; i++) begin
            int c = i % 6;
            #1;
            chk("R4 up pwm_a", int'(ref1), int'(c < 2));
            chk("R4 up pwm_b", int'(ref2), int'(c >= 2));
            chk("R11 merged passthrough", int'(ref1_merged), int'(c < 2));
            cyc();
        end
        for (int i = 12; i < 24; i++) begin
            int c = i % 6;
            int cv = (i >= 18) ? 4 : 2;
            cmp1_we = (i == 13); cmp1_wdata = W'(4);
            #1;
            chk("R3 compare preload", int'(ref1), int'(c < cv));
            cyc();
        end
        cmp1_we = 1'b0;
        mode2 = 4'd6;
        load(5, 0, 7);
        run = 1'b1;
        for (int i = 0; i < 6; i++) begin
            #1;
            chk("R4 zero compare low", int'(ref1), 0);
            chk("R4 compare above limit high", int'(ref2), 1);
            cyc();
        end
    endtask

    task automatic t_down();
        cnt_mode = 2'd1; mode1 = 4'd6; mode2 = 4'd7;
        load(3, 1, 1);
        run = 1'b1;
        for (int i = 0; i < 8; i++) begin
            int c = 3 - (i % 4);
            #1;
            chk("R2 down cnt", int'(cnt), c);
            chk("R2 down flag", int'(cnt_down), 1);
            chk("R2 down update", int'(update_evt), int'(c == 0));
            chk("R4 down pwm_a", int'(ref1), int'(c <= 1));
            chk("R4 down pwm_b", int'(ref2), int'(c > 1));
            cyc();
        end
    endtask

    task automatic t_center();
        int cs[6] = '{1, 2, 3, 2, 1, 0};
        int ds[6] = '{0, 0, 0, 1, 1, 1};
        cnt_mode = 2'd2; mode1 = 4'd14; mode2 = 4'd7;
        load(3, 1, 2);
        run = 1'b1;
        #1;
        chk("R2 center start cnt", int'(cnt), 0);
        chk("R2 center start dir", int'(cnt_down), 0);
        cyc();
        for (int i = 1; i < 19; i++) begin
            int k = (i - 1) % 6;
            int c = cs[k];
            int d = ds[k];
            int e1, e2;
            if (i == 13) mode1 = 4'd15;
            e1 = (i >= 13) ? 1 - pwm_a(c, 1, d) : pwm_a(c, 1, d);
            e2 = 1 - pwm_a(c, 2, d);
            #1;
            chk("R2 center cnt", int'(cnt), c);
            chk("R2 center dir", int'(cnt_down), d);
            chk("R2 center update", int'(update_evt), int'(k == 2 || k == 5));
            chk("R12 asym ref1", int'(ref1), e1);
            chk("R12 asym merged", int'(ref1_merged), (d != 0) ? e2 : e1);
            cyc();
        end
    endtask

    task automatic t_comb();
        cnt_mode = 2'd0; mode1 = 4'd12; mode2 = 4'd7;
        load(5, 1, 4);
        run = 1'b1;
        for (int i = 0; i < 12; i++) begin
            int c = i % 6;
            if (i == 6) mode1 = 4'd13;
            #1;
            if (i < 6) begin
                chk("R11 comb or", int'(ref1_merged), int'(c < 1 || c >= 4));
            end else begin
                chk("R11 comb and ref1", int'(ref1), int'(c >= 1));
                chk("R11 comb and", int'(ref1_merged), int'(c >= 1 && c >= 4));
            end
            cyc();
        end
    endtask

    task automatic t_match();
        cnt_mode = 2'd0; mode1 = 4'd4; mode2 = 4'd5;
        load(5, 3, 3);
        #1;
        chk("R7 force low", int'(ref1), 0);
        chk("R7 force high", int'(ref2), 1);
        mode1 = 4'd1; mode2 = 4'd2; run = 1'b1;
        for (int i = 0; i < 12; i++) begin
            #1;
            chk("R5 match cnt", int'(cnt), i % 6);
            chk("R5 set on match", int'(ref1), int'(i >= 4));
            chk("R5 clear on match", int'(ref2), int'(i < 4));
            cyc();
        end
        for (int j = 0; j < 15; j++) begin
            mode1 = 4'd3;
            mode2 = (j == 0) ? 4'd5 : 4'd0;
            #1;
            chk("R6 toggle", int'(ref1), 1 ^ (((j + 2) / 6) % 2));
            chk("R7 frozen holds", int'(ref2), 1);
            cyc();
        end
        run = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R13 stopped cnt", int'(cnt), 3);
            chk("R13 no toggle when stopped", int'(ref1), 1);
            cyc();
        end
    endtask

    task automatic t_opm();
        cnt_mode = 2'd0; mode1 = 4'd8; mode2 = 4'd9; trig = 1'b0;
        load(5, 2, 2);
        run = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #1;
            chk("R8 idle up", int'(ref1), 1);
            chk("R9 idle up", int'(ref2), 0);
            cyc();
        end
        trig = 1'b1;
        #1;
        chk("R10 cnt before trigger", int'(cnt), 2);
        cyc();
        trig = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R10 restart cnt", int'(cnt), k);
            chk("R8 armed", int'(ref1), int'(k < 2));
            chk("R9 armed", int'(ref2), int'(k >= 2));
            cyc();
        end
        trig = 1'b1;
        #1;
        chk("R10 cnt before retrigger", int'(cnt), 3);
        cyc();
        trig = 1'b0;
        for (int m = 0; m < 9; m++) begin
            int c = m % 6;
            #1;
            chk("R10 retrigger cnt", int'(cnt), c);
            chk("R8 pulse then rest", int'(ref1), (m <= 5) ? int'(c < 2) : 1);
            chk("R9 pulse then rest", int'(ref2), (m <= 5) ? int'(c >= 2) : 0);
            cyc();
        end
        cnt_mode = 2'd1;
        load(3, 1, 1);
        run = 1'b1;
        #1;
        chk("R8 idle down", int'(ref1), 0);
        chk("R9 idle down", int'(ref2), 1);
        trig = 1'b1;
        cyc();
        trig = 1'b0;
        for (int k = 0; k < 5; k++) begin
            int c = (k <= 3) ? 3 - k : 3;
            #1;
            chk("R10 down restart cnt", int'(cnt), c);
            chk("R8 down armed", int'(ref1), (k <= 3) ? int'(c <= 1) : 0);
            chk("R9 down armed", int'(ref2), (k <= 3) ? int'(c > 1) : 1);
            cyc();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_count_up();
        t_pwm_up();
        t_down();
        t_center();
        t_comb();
        t_match();
        t_opm();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule